// File: doc/BRIEF.md
# Dual-Channel Compare-Match Timer

This peripheral holds two independent 16-bit up-counters behind a small synchronous register bus. Each channel has its own clock prescaler. The prescaler turns the peripheral clock into a count-enable tick every 8, 32, 128 or 512 cycles, and the channel's control register picks the ratio. On every tick the channel compares its count against its own compare register. When the two are equal, the counter returns to zero instead of incrementing. If the channel's interrupt enable is set, the matching interrupt output goes high for exactly one clock.

Software starts and stops both channels through one shared start register, with one bit per channel. The counter and compare registers can be written at any time, whether the channel is running or stopped. A stopped channel keeps its count and its prescaler is held at zero, so a restart always begins a full prescale interval. The bus has no handshake. A write takes effect at the clock edge on which the write enable is sampled high. Read data is a combinational function of the address.

Top module: `dual_match_timer`

## Requirements
- R1: After reset the start register, both control registers and both counters read 0 and both compare registers read 0xFFFF. The 16-bit register map is: start at 0x0; channel 0 control, count and compare at 0x2, 0x4 and 0x6; channel 1 control, count and compare at 0x8, 0xA and 0xC.
- R2: Start register bit 0 runs channel 0 and bit 1 runs channel 1. All other start bits are not stored and read as 0.
- R3: Control register bit 6 is the interrupt enable and bits [1:0] are the divide select. No other control bit is stored, and those bits read as 0.
- R4: Divide select 00, 01, 10 and 11 give prescale ratios D of 8, 32, 128 and 512. With compare value N, a running channel matches every (N+1)·D clocks. The first match comes (N+1)·D clocks after the edge that sets its start bit.
- R5: On a match the counter is cleared to 0 and counting goes on, so successive matches are spaced by the same (N+1)·D period.
- R6: An interrupt output goes high for exactly one clock after each match of its channel. It does so only while that channel's interrupt enable is 1, and never otherwise.
- R7: While a channel's start bit is 0, its count does not change except by a bus write, and it reads back as held.
- R8: A read from any unmapped address, including 0xE and odd addresses, returns 0xFFFF. A write to such an address changes no register.
- R9: The two channels count, match and interrupt independently when they run at the same time with different settings.
- R10: If a bus write to a channel's counter lands on the same edge as that channel's match, the counter takes the written value. The interrupt pulse for that match is still issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Byte address of the 16-bit register |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for `addr` |
| irq | output | 2 | One-clock match interrupt pulses, bit c for channel c |

## Verification
A counter write from the bus and a compare match of the same channel can fall on one clock edge. The bench provokes this by starting channel 0 with divide-by-8 and compare value 2. It counts 23 clocks, then issues the counter write so that it is sampled on edge 24, the edge of the match tick. The result is judged on the next falling edge: the counter must read the written value rather than zero, and the interrupt output must be high.

// File: rtl/dmt_pkg.sv
`timescale 1ns/1ps
package dmt_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 16;
  localparam int NUM_CH   = 2;
  localparam int SEL_W    = 2;
  localparam int IE_BIT   = 6;
  localparam int PRE_BASE = 3;   // log2 of the smallest ratio
  localparam int PRE_STEP = 2;   // log2 growth per select step
  localparam int PRE_W    = PRE_BASE + PRE_STEP * ((1 << SEL_W) - 1);

  localparam logic [ADDR_W-1:0] START_ADDR = '0;

  function automatic logic [ADDR_W-1:0] ctl_addr(input int ch);
    return ADDR_W'(2 + 6 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] cnt_addr(input int ch);
    return ADDR_W'(4 + 6 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] cmp_addr(input int ch);
    return ADDR_W'(6 + 6 * ch);
  endfunction
endpackage

// File: rtl/dmt_prescaler.sv
`timescale 1ns/1ps
module dmt_prescaler
  import dmt_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int BASE = PRE_BASE,
  parameter int STEP = PRE_STEP,
  localparam int PW = BASE + STEP * ((1 << SW) - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [SW-1:0] sel,
  output logic          tick
);
  logic [PW-1:0] div_q;
  logic [PW:0]   last;

  // last phase of the selected ratio: 2^(BASE+STEP*sel) - 1
  always_comb begin
    last = ((PW+1)'(1) << (BASE + STEP * int'(sel))) - (PW+1)'(1);
  end

  // >= keeps a ratio change mid-interval from stalling the divider
  assign tick = run && ({1'b0, div_q} >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (!run || tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + PW'(1);
    end
  end
endmodule

// File: rtl/dmt_channel.sv
`timescale 1ns/1ps
module dmt_channel
  import dmt_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [SW-1:0] sel,
  input  logic          ie,
  input  logic          cnt_we,
  input  logic          cmp_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] count,
  output logic [DW-1:0] compare,
  output logic          irq
);
  logic tick;
  logic hit;

  dmt_prescaler #(.SW(SW)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .sel  (sel),
    .tick (tick)
  );

  assign hit = tick && (count == compare);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      compare <= '1;
      irq     <= 1'b0;
    end else begin
      irq <= hit && ie;
      // bus write outranks the count update on the same edge
      if (cnt_we) begin
        count <= wdata;
      end else if (hit) begin
        count <= '0;
      end else if (tick) begin
        count <= count + DW'(1);
      end
      if (cmp_we) begin
        compare <= wdata;
      end
    end
  end
endmodule

// File: rtl/dmt_regs.sv
`timescale 1ns/1ps
module dmt_regs
  import dmt_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int DW = DATA_W,
  parameter int SW = SEL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wr_en,
  input  logic [NCH-1:0]         wr_start,
  input  logic                   wr_ie,
  input  logic [SW-1:0]          wr_sel,
  input  logic [NCH-1:0][DW-1:0] cnt_in,
  input  logic [NCH-1:0][DW-1:0] cmp_in,
  output logic [NCH-1:0]         run,
  output logic [NCH-1:0]         ie,
  output logic [NCH-1:0][SW-1:0] sel,
  output logic [NCH-1:0]         cnt_we,
  output logic [NCH-1:0]         cmp_we,
  output logic [DW-1:0]          rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
    end else if (wr_en && addr == START_ADDR) begin
      run <= wr_start;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign cnt_we[c] = wr_en && (addr == cnt_addr(c));
    assign cmp_we[c] = wr_en && (addr == cmp_addr(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ie[c]  <= 1'b0;
        sel[c] <= '0;
      end else if (wr_en && addr == ctl_addr(c)) begin
        ie[c]  <= wr_ie;
        sel[c] <= wr_sel;
      end
    end
  end

  always_comb begin
    rd_data = '1;
    if (addr == START_ADDR) begin
      rd_data = '0;
      rd_data[NCH-1:0] = run;
    end
    for (int c = 0; c < NCH; c++) begin
      if (addr == ctl_addr(c)) begin
        rd_data = '0;
        rd_data[IE_BIT] = ie[c];
        rd_data[SW-1:0] = sel[c];
      end else if (addr == cnt_addr(c)) begin
        rd_data = cnt_in[c];
      end else if (addr == cmp_addr(c)) begin
        rd_data = cmp_in[c];
      end
    end
  end
endmodule

// File: rtl/dual_match_timer.sv
`timescale 1ns/1ps
module dual_match_timer
  import dmt_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int DW = DATA_W,
  parameter int SW = SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  output logic [NCH-1:0]    irq
);
  logic [NCH-1:0]         run_w;
  logic [NCH-1:0]         ie_w;
  logic [NCH-1:0][SW-1:0] sel_w;
  logic [NCH-1:0]         cnt_we_w;
  logic [NCH-1:0]         cmp_we_w;
  logic [NCH-1:0][DW-1:0] cnt_w;
  logic [NCH-1:0][DW-1:0] cmp_w;

  dmt_regs #(.NCH(NCH), .DW(DW), .SW(SW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_start(wr_data[NCH-1:0]),
    .wr_ie   (wr_data[IE_BIT]),
    .wr_sel  (wr_data[SW-1:0]),
    .cnt_in  (cnt_w),
    .cmp_in  (cmp_w),
    .run     (run_w),
    .ie      (ie_w),
    .sel     (sel_w),
    .cnt_we  (cnt_we_w),
    .cmp_we  (cmp_we_w),
    .rd_data (rd_data)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dmt_channel #(.DW(DW), .SW(SW)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_w[c]),
      .sel    (sel_w[c]),
      .ie     (ie_w[c]),
      .cnt_we (cnt_we_w[c]),
      .cmp_we (cmp_we_w[c]),
      .wdata  (wr_data),
      .count  (cnt_w[c]),
      .compare(cmp_w[c]),
      .irq    (irq[c])
    );
  end
endmodule

// File: rtl/dmt_checker.sv
`timescale 1ns/1ps
module dmt_checker
  import dmt_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int DW = DATA_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      addr,
  input logic [DW-1:0]          rd_data,
  input logic [NCH-1:0]         irq,
  input logic [NCH-1:0]         run,
  input logic [NCH-1:0]         ie,
  input logic [NCH-1:0]         cnt_we,
  input logic [NCH-1:0][DW-1:0] count
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |=> !irq[c]);
    a_r6_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> $past(ie[c]));
    a_r7_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[c] && !cnt_we[c]) |=> $stable(count[c]));
    a_r5_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[c] && !$past(cnt_we[c])) |-> (count[c] == '0));
  end

  a_r8_unmapped_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(14) || addr[0]) |-> (rd_data == '1));
  a_r2_start_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == START_ADDR) |-> (rd_data[DW-1:NCH] == '0));
endmodule

bind dual_match_timer dmt_checker #(.NCH(NCH), .DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .addr   (addr),
  .rd_data(rd_data),
  .irq    (irq),
  .run    (run_w),
  .ie     (ie_w),
  .cnt_we (cnt_we_w),
  .count  (cnt_w)
);

// File: tb/sim_dual_match_timer.sv
`timescale 1ns/1ps
module sim_dual_match_timer;
  logic        clk;
  logic        rst_n;
  logic [3:0]  addr;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [1:0]  irq;

  int n_cmp = 0;
  int n_bad = 0;

  dual_match_timer u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  // vectors: channel, divide select, compare value, expected period in clocks
  localparam int NV = 6;
  localparam int V_CH  [NV] = '{0, 0, 0, 0, 1, 1};
  localparam int V_SEL [NV] = '{0, 1, 2, 3, 0, 2};
  localparam int V_CMP [NV] = '{4, 2, 1, 0, 9, 0};
  localparam int V_PER [NV] = '{40, 96, 256, 512, 80, 128};

  task automatic check(input string req, input string what, input int got, input int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // called at a falling edge; the write is taken on the next rising edge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 4'h0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    addr = a;
    #1;
    v = int'(rd_data);
    addr = 4'h0;
  endtask

  task automatic wait_irq(input int ch, input int limit, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!irq[ch] && k < limit);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL R4 watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int v, k;
    int h0, h1;
    logic [3:0] ctl, cnt, cmp;
    addr = 4'h0; wr_en = 1'b0; wr_data = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values at their offsets
    check("R1", "irq after reset", int'(irq), 0);
    rd(4'h0, v); check("R1", "start", v, 0);
    rd(4'h2, v); check("R1", "ctl0", v, 0);
    rd(4'h4, v); check("R1", "cnt0", v, 0);
    rd(4'h6, v); check("R1", "cmp0", v, 16'hFFFF);
    rd(4'h8, v); check("R1", "ctl1", v, 0);
    rd(4'hA, v); check("R1", "cnt1", v, 0);
    rd(4'hC, v); check("R1", "cmp1", v, 16'hFFFF);

    // R8 unmapped reads and ignored writes
    rd(4'hE, v); check("R8", "read 0xE", v, 16'hFFFF);
    rd(4'h5, v); check("R8", "read odd 0x5", v, 16'hFFFF);
    wr(4'hE, 16'h1234);
    wr(4'h3, 16'h0042);
    rd(4'h0, v); check("R8", "start after stray writes", v, 0);
    rd(4'h2, v); check("R8", "ctl0 after stray writes", v, 0);
    rd(4'h4, v); check("R8", "cnt0 after stray writes", v, 0);
    rd(4'h6, v); check("R8", "cmp0 after stray writes", v, 16'hFFFF);
    rd(4'hC, v); check("R8", "cmp1 after stray writes", v, 16'hFFFF);

    // R2 start register bits
    wr(4'h0, 16'hFFFC); rd(4'h0, v); check("R2", "start upper bits", v, 0);
    wr(4'h0, 16'hFFFF); rd(4'h0, v); check("R2", "start both", v, 3);
    wr(4'h0, 16'h0000);

    // R3 control fields
    wr(4'h2, 16'hFFFF); rd(4'h2, v); check("R3", "ctl0 all ones", v, 16'h0043);
    wr(4'h8, 16'h0002); rd(4'h8, v); check("R3", "ctl1 sel only", v, 16'h0002);
    wr(4'h2, 16'h0000); wr(4'h8, 16'h0000);

    // R4/R5 match period table
    for (int i = 0; i < NV; i++) begin
      ctl = (V_CH[i] == 0) ? 4'h2 : 4'h8;
      cnt = ctl + 4'h2;
      cmp = ctl + 4'h4;
      wr(4'h0, 16'h0000);
      wr(ctl, 16'h0040 | 16'(V_SEL[i]));
      wr(cmp, 16'(V_CMP[i]));
      wr(cnt, 16'h0000);
      wr(4'h0, 16'(1 << V_CH[i]));
      wait_irq(V_CH[i], 2000, k);
      check("R4", $sformatf("first period vec %0d", i), k, V_PER[i]);
      rd(cnt, v); check("R5", $sformatf("count cleared vec %0d", i), v, 0);
      wait_irq(V_CH[i], 2000, k);
      check("R5", $sformatf("second period vec %0d", i), k, V_PER[i]);
    end
    wr(4'h0, 16'h0000);

    // R6 interrupt disabled
    wr(4'hA, 16'h0000); wr(4'hC, 16'h0001); wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0002);
    h1 = 0;
    for (int j = 0; j < 200; j++) begin
      @(negedge clk);
      if (irq[1]) h1++;
    end
    check("R6", "irq1 with enable clear", h1, 0);
    wr(4'h0, 16'h0000);

    // R7 stopped channel holds its count
    wr(4'h2, 16'h0000); wr(4'h6, 16'hFFFF); wr(4'h4, 16'h0000);
    wr(4'h0, 16'h0001);
    repeat (99) @(negedge clk);
    wr(4'h0, 16'h0000);
    rd(4'h4, v); check("R7", "count at stop", v, 12);
    repeat (50) @(negedge clk);
    rd(4'h4, v); check("R7", "count held", v, 12);

    // R9 independent channels
    wr(4'h2, 16'h0040); wr(4'h6, 16'h0009); wr(4'h4, 16'h0000);
    wr(4'h8, 16'h0041); wr(4'hC, 16'h0004); wr(4'hA, 16'h0000);
    wr(4'h0, 16'h0003);
    h0 = 0; h1 = 0;
    for (int j = 1; j <= 480; j++) begin
      @(negedge clk);
      if (irq[0]) h0++;
      if (irq[1]) h1++;
    end
    check("R9", "irq0 pulses in 480", h0, 6);
    check("R9", "irq1 pulses in 480", h1, 3);
    wr(4'h0, 16'h0000);

    // R10 counter write on the match edge
    wr(4'h2, 16'h0040); wr(4'h6, 16'h0002); wr(4'h4, 16'h0000);
    wr(4'h0, 16'h0001);
    repeat (23) @(negedge clk);
    wr(4'h4, 16'h0100);
    check("R10", "irq on write-match edge", int'(irq[0]), 1);
    rd(4'h4, v); check("R10", "written count wins", v, 16'h0100);
    wr(4'h0, 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule